// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block sits between one core and a shared memory port and makes a linked-load / conditional-store pair behave atomically. When the core issues a linked load, the read goes to memory unchanged, and the block records which aligned word was read along with a held flag. A later conditional store is let through to memory only if the flag is still set and the store targets the same word. One cycle later the block reports the outcome to the core: 1 when the store was performed and 0 when it was suppressed.

The block also watches the writes that other agents make to the shared memory. Any such write that lands on the reserved word cancels the reservation, so a conditional store that follows it fails. Software retries the sequence when it sees a 0. Ordinary loads and stores from the core go to the port with no condition.

Top module: `resv_monitor`

## Requirements
- R1: After reset the reservation is not held (`resv_held`=0) and `sc_done` is 0. A conditional store issued right after reset fails.
- R2: A request with `core_kind`=2'b10 (linked load) drives `mem_re`=1 with `mem_addr`=`core_addr` in the same cycle and sets `resv_held` from the next cycle. The exception is a same-cycle write by another agent to that word, which leaves the reservation unset.
- R3: A request with `core_kind`=2'b11 (conditional store) that finds a held reservation on its word drives `mem_we`=1 in the same cycle. In the next cycle it gives `sc_done`=1 and `sc_ok`=1.
- R4: A conditional store that fails keeps `mem_we`=0 and gives `sc_done`=1 and `sc_ok`=0 in the next cycle.
- R5: Every conditional store clears the reservation, whether it succeeds or fails.
- R6: A write by another agent (`snoop_we`=1) to the reserved word clears the reservation. A write to a different word leaves it held.
- R7: An ordinary core store (`core_kind`=2'b01) to the reserved word clears the reservation. A store to a different word leaves it held.
- R8: A new linked load replaces any existing reservation, so a conditional store to the earlier word fails.
- R9: A conditional store to a word other than the reserved one fails.
- R10: Words are matched on address bits [AW-1:OFS], which is [31:2] by default. Two byte addresses inside the same word count as the same location.
- R11: If another agent writes the word in the same cycle as a conditional store to it, the store fails.
- R12: An ordinary load (`core_kind`=2'b00) drives `mem_re`=1 and an ordinary store drives `mem_we`=1 with no condition. Neither of them raises `sc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present this cycle |
| core_kind | input | 2 | 00 load, 01 store, 10 linked load, 11 conditional store |
| core_addr | input | AW | Byte address of the request |
| core_wdata | input | DW | Store data |
| mem_re | output | 1 | Read strobe to memory |
| mem_we | output | 1 | Write strobe to memory |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| sc_done | output | 1 | Conditional-store outcome valid (one cycle after the request) |
| sc_ok | output | 1 | 1 when the conditional store was performed, 0 when suppressed |
| snoop_we | input | 1 | Another agent writes memory this cycle |
| snoop_addr | input | AW | Byte address of that write |
| resv_held | output | 1 | A reservation is currently held |

## Verification
The bench builds the block with its defaults: AW=32, DW=32 and OFS=2, which gives a 30-bit word tag. With OFS=2, the bench can hit the same word through byte offsets 1, 2 and 3, which exercises the granularity match. Addresses 0x100 and 0x200 differ only in tag bits. Together they expose false matches and missed matches in the snoop comparison, the core-store comparison and the conditional-store comparison.

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int OFS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_valid,
  input  logic [1:0]    core_kind,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          sc_done,
  output logic          sc_ok,
  input  logic          snoop_we,
  input  logic [AW-1:0] snoop_addr,
  output logic          resv_held
);
  localparam int TW = AW - OFS;

  logic [TW-1:0] resv_tag;
  logic          resv_q;

  wire [TW-1:0] core_tag  = core_addr[AW-1:OFS];
  wire [TW-1:0] snoop_tag = snoop_addr[AW-1:OFS];

  wire is_ld = core_valid && core_kind == 2'b00;
  wire is_st = core_valid && core_kind == 2'b01;
  wire is_ll = core_valid && core_kind == 2'b10;
  wire is_sc = core_valid && core_kind == 2'b11;

  wire core_on_resv    = resv_q && core_tag == resv_tag;
  wire snoop_on_core   = snoop_we && snoop_tag == core_tag;
  wire snoop_on_resv   = resv_q && snoop_we && snoop_tag == resv_tag;
  wire sc_pass         = is_sc && core_on_resv && !snoop_on_core;
  wire resv_kill       = is_sc || snoop_on_resv || (is_st && core_on_resv);

  assign mem_re    = is_ld || is_ll;
  assign mem_we    = is_st || sc_pass;
  assign mem_addr  = core_addr;
  assign mem_wdata = core_wdata;
  assign resv_held = resv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_q   <= 1'b0;
      resv_tag <= '0;
      sc_done  <= 1'b0;
      sc_ok    <= 1'b0;
    end else begin
      sc_done <= is_sc;
      sc_ok   <= sc_pass;
      if (is_ll) begin
        resv_q   <= !snoop_on_core;
        resv_tag <= core_tag;
      end else if (resv_kill) begin
        resv_q <= 1'b0;
      end
    end
  end
endmodule

module resv_monitor_chk #(
  parameter int AW  = 32,
  parameter int OFS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_valid,
  input logic [1:0]      core_kind,
  input logic [AW-1:0]   core_addr,
  input logic            mem_we,
  input logic            sc_done,
  input logic            sc_ok,
  input logic            snoop_we,
  input logic [AW-1:0]   snoop_addr,
  input logic            resv_held,
  input logic [AW-OFS-1:0] resv_tag
);
  // R3
  sc_write_needs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_kind == 2'b11 && mem_we) |-> resv_held);
  // R5
  sc_drops_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_kind == 2'b11) |=> !resv_held);
  // R2
  ll_sets_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_kind == 2'b10 &&
     !(snoop_we && snoop_addr[AW-1:OFS] == core_addr[AW-1:OFS])) |=> resv_held);
  // R4
  sc_result_matches_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sc_done) |-> (sc_ok == $past(mem_we)));
  // R6
  snoop_drops_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resv_held && snoop_we && snoop_addr[AW-1:OFS] == resv_tag &&
     !(core_valid && core_kind == 2'b10)) |=> !resv_held);
  // R12
  done_only_after_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> $past(core_valid && core_kind == 2'b11));
endmodule

bind resv_monitor resv_monitor_chk #(.AW(AW), .OFS(OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_kind(core_kind),
  .core_addr(core_addr), .mem_we(mem_we), .sc_done(sc_done), .sc_ok(sc_ok),
  .snoop_we(snoop_we), .snoop_addr(snoop_addr), .resv_held(resv_held),
  .resv_tag(resv_tag)
);

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_valid = 1'b0;
  logic [1:0]  core_kind = 2'b00;
  logic [31:0] core_addr = '0;
  logic [31:0] core_wdata = '0;
  logic        snoop_we = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic        mem_re, mem_we, sc_done, sc_ok, resv_held;
  logic [31:0] mem_addr, mem_wdata;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  resv_monitor u_resv_monitor (
    .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_kind(core_kind),
    .core_addr(core_addr), .core_wdata(core_wdata), .mem_re(mem_re),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sc_done(sc_done), .sc_ok(sc_ok), .snoop_we(snoop_we),
    .snoop_addr(snoop_addr), .resv_held(resv_held)
  );

  typedef struct packed {
    logic        v;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic        swe;
    logic [31:0] saddr;
    logic        re;
    logic        we;
    logic        ok;
    logic        held;
  } vec_t;

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  localparam vec_t VECS [19] = '{
    '{1'b1, LL, 32'h100, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b1}, // R2
    '{1'b1, SC, 32'h102, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1, 1'b0}, // R3 R10 R5
    '{1'b1, SC, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{1'b1, LL, 32'h100, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b0, LD, 32'h0,   1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 other word
    '{1'b0, LD, 32'h0,   1'b1, 32'h101, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 same word
    '{1'b1, SC, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{1'b1, LL, 32'h100, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b1, ST, 32'h200, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b1}, // R7 other word
    '{1'b1, ST, 32'h103, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0}, // R7 same word
    '{1'b1, LL, 32'h100, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b1, LL, 32'h200, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b1}, // R8
    '{1'b1, SC, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0}, // R8
    '{1'b1, LL, 32'h200, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b1, SC, 32'h300, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0}, // R9
    '{1'b1, LL, 32'h100, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b1, SC, 32'h100, 1'b1, 32'h102, 1'b0, 1'b0, 1'b0, 1'b0}, // R11
    '{1'b1, LL, 32'h100, 1'b1, 32'h100, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 corner
    '{1'b1, LD, 32'h100, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b0}  // R12
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic [31:0] a,
                       input logic sw, input logic [31:0] sa);
    core_valid = v; core_kind = k; core_addr = a;
    core_wdata = a ^ 32'h5a5a0000; snoop_we = sw; snoop_addr = sa;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 held", {31'b0, resv_held}, 32'd0);
    check("R1 done", {31'b0, sc_done}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 19; i++) begin
      vec_t t;
      t = VECS[i];
      drive(t.v, t.kind, t.addr, t.swe, t.saddr);
      #1;
      check($sformatf("R2/R12 re v%0d", i), {31'b0, mem_re}, {31'b0, t.re});
      check($sformatf("R3/R4 we v%0d", i), {31'b0, mem_we}, {31'b0, t.we});
      check($sformatf("R12 addr v%0d", i), mem_addr, t.addr);
      @(negedge clk);
      check($sformatf("R12 done v%0d", i), {31'b0, sc_done},
            {31'b0, (t.v && t.kind == SC)});
      if (t.v && t.kind == SC)
        check($sformatf("R3/R4 ok v%0d", i), {31'b0, sc_ok}, {31'b0, t.ok});
      check($sformatf("R5-R11 held v%0d", i), {31'b0, resv_held}, {31'b0, t.held});
    end

    // R1: reset drops a live reservation; SC after reset fails
    drive(1'b1, LL, 32'h400, 1'b0, 32'h0);
    @(negedge clk);
    check("R2 held before reset", {31'b0, resv_held}, 32'd1);
    drive(1'b0, LD, 32'h0, 1'b0, 32'h0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 held after reset", {31'b0, resv_held}, 32'd0);
    rst_n = 1'b1;
    drive(1'b1, SC, 32'h400, 1'b0, 32'h0);
    #1;
    check("R1 sc we after reset", {31'b0, mem_we}, 32'd0);
    @(negedge clk);
    check("R1 sc done", {31'b0, sc_done}, 32'd1);
    check("R1 sc ok", {31'b0, sc_ok}, 32'd0);
    drive(1'b0, LD, 32'h0, 1'b0, 32'h0);
    @(negedge clk);
    check("R12 done idle", {31'b0, sc_done}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule